// File: doc/BRIEF.md
# RTC Prescaler and Tick-Rate Controller

This block sits at the front of a real-time clock that runs from a 32.768 kHz crystal. It holds a small control word that software writes over a simple register bus. The word sets a master enable, a periodic tick rate and two test-mode bits, and it can restart the divider chain. A 15-bit binary divider counts crystal cycles. When the divider wraps, the block raises a one-cycle enable once per second. The time-of-day counters downstream use this enable to advance.

A second output gives a programmable tick pulse taken from the divider taps. Its rate is set by a 4-bit rate code, and this code does not run in order of period. An override bit replaces the code with the raw crystal rate. The master enable goes out as a write-permit level. The counter registers downstream use it to block CPU access while the clock is unlocked.

Top module: `rtc_tick_ctrl`

## Requirements
- R1: While reset is asserted, the control word reads as 0x000, the write-permit output is low, and the divider is held at zero.
- R2: Bit 0 of the control word is the master enable and can always be written. The write-permit output equals bit 0 from the cycle after the write.
- R3: Bits 1 and 2 read back exactly as written and have no effect on the tick or seconds outputs.
- R4: The seconds enable is high for one cycle in every 32768 crystal cycles. This is the cycle in which the divider holds 32767.
- R5: A write with bit 3 set clears the divider at that clock edge. The divider is zero in the following cycle. Bit 3 is never stored and always reads 0.
- R6: When bit 4 is 1, the tick output is high in every cycle, whatever bits [8:5] hold.
- R7: When bit 4 is 0, bits [8:5] choose the tick period in crystal cycles: 0→2, 1→4, 2→8, 3→16, 4→256, 5→32768, 6→32, 7→64, 8→128, 9→512, 10→1024, 11→2048, 12→4096, 13→8192, 14→16384. The first tick comes period−1 cycles after a divider clear.
- R8: Rate code 15 with bit 4 at 0 produces no tick at all.
- R9: When the period is 2 or more, each tick lasts exactly one cycle.
- R10: A write to any address other than the control address leaves the control word unchanged. A read of any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 9 | Write data |
| bus_rdata | output | 9 | Read data, combinational from the address |
| cnt_wr_permit | output | 1 | Access permit for the downstream time counters |
| sec_en | output | 1 | One-cycle enable, once per second |
| tick_pulse | output | 1 | Periodic tick at the selected rate |

## Verification
The assertions assume that a write strobe lasts a single cycle. They also assume that the rate code and the override change only through a write to the control address. For this reason, the single-pulse property ignores cycles that carry a control write. The bench drives each write for exactly one cycle and holds the bus idle while it watches ticks. Every tick-observation phase begins with a write that also clears the divider, so expected tick and seconds times are counted from that edge alone.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
  localparam int DIV_W   = 15;
  localparam int CTRL_W  = 9;
  localparam int EXP_W   = $clog2(DIV_W + 1);
  localparam int B_EN    = 0;
  localparam int B_XSEL  = 1;
  localparam int B_SPLIT = 2;
  localparam int B_CLR   = 3;
  localparam int B_OVR   = 4;
  localparam int B_CODE  = 5;

  typedef struct packed {
    logic [3:0] code;
    logic       ovr;
    logic       split;
    logic       xsel;
    logic       en;
  } ctrl_t;

  typedef struct packed {
    logic             live;
    logic [EXP_W-1:0] k;
  } tap_t;

  // rate code -> divider tap exponent (period = 2**k crystal cycles)
  function automatic tap_t pick_tap(input logic ovr, input logic [3:0] code);
    tap_t r;
    r.live = 1'b1;
    r.k    = '0;
    if (!ovr) begin
      unique case (code)
        4'd0:  r.k = EXP_W'(1);
        4'd1:  r.k = EXP_W'(2);
        4'd2:  r.k = EXP_W'(3);
        4'd3:  r.k = EXP_W'(4);
        4'd4:  r.k = EXP_W'(8);
        4'd5:  r.k = EXP_W'(15);
        4'd6:  r.k = EXP_W'(5);
        4'd7:  r.k = EXP_W'(6);
        4'd8:  r.k = EXP_W'(7);
        4'd9:  r.k = EXP_W'(9);
        4'd10: r.k = EXP_W'(10);
        4'd11: r.k = EXP_W'(11);
        4'd12: r.k = EXP_W'(12);
        4'd13: r.k = EXP_W'(13);
        4'd14: r.k = EXP_W'(14);
        default: r.live = 1'b0;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_tick_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic              clr_now,
  output logic [CTRL_W-1:0] rdata
);
  logic  hit;
  ctrl_t ctrl_q;

  assign hit     = (addr == CTRL_ADDR);
  assign clr_now = hit && we && wdata[B_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (hit && we) begin
      ctrl_q.en    <= wdata[B_EN];
      ctrl_q.xsel  <= wdata[B_XSEL];
      ctrl_q.split <= wdata[B_SPLIT];
      ctrl_q.ovr   <= wdata[B_OVR];
      ctrl_q.code  <= wdata[B_CODE +: 4];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[B_EN]       = ctrl_q.en;
      rdata[B_XSEL]     = ctrl_q.xsel;
      rdata[B_SPLIT]    = ctrl_q.split;
      rdata[B_OVR]      = ctrl_q.ovr;
      rdata[B_CODE +: 4] = ctrl_q.code;
    end
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int WIDTH = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [WIDTH-1:0] div_q,
  output logic             wrap
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  assign div_q = cnt_q;
  assign wrap  = &cnt_q;
endmodule

// File: rtl/rtc_tick_sel.sv
module rtc_tick_sel
  import rtc_tick_pkg::*;
#(
  parameter int WIDTH = 15
) (
  input  logic [WIDTH-1:0] div_q,
  input  tap_t             tap,
  output logic             tick
);
  logic [WIDTH:0] tap_full;

  // tap_full[i]: low i divider bits all ones (period 2**i)
  assign tap_full[0] = 1'b1;
  generate
    for (genvar i = 1; i <= WIDTH; i++) begin : g_tap
      assign tap_full[i] = &div_q[i-1:0];
    end
  endgenerate

  assign tick = tap.live && tap_full[tap.k];
endmodule

// File: rtl/rtc_tick_ctrl.sv
module rtc_tick_ctrl
  import rtc_tick_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input  logic              clk_xtal,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] bus_rdata,
  output logic              cnt_wr_permit,
  output logic              sec_en,
  output logic              tick_pulse
);
  ctrl_t            ctrl;
  logic             clr_now;
  logic [DIV_W-1:0] div_q;
  tap_t             tap;
  logic             tick_ovr;
  logic [3:0]       tick_code;

  rtc_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
    .clk(clk_xtal), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
    .wdata(bus_wdata), .ctrl(ctrl), .clr_now(clr_now), .rdata(bus_rdata)
  );

  rtc_prescaler #(.WIDTH(DIV_W)) u_div (
    .clk(clk_xtal), .rst_n(rst_n), .clr(clr_now), .div_q(div_q), .wrap(sec_en)
  );

  assign tick_ovr  = ctrl.ovr;
  assign tick_code = ctrl.code;
  assign tap       = pick_tap(tick_ovr, tick_code);

  rtc_tick_sel #(.WIDTH(DIV_W)) u_tick (
    .div_q(div_q), .tap(tap), .tick(tick_pulse)
  );

  assign cnt_wr_permit = ctrl.en;
endmodule

// File: rtl/rtc_tick_ctrl_chk.sv
module rtc_tick_ctrl_chk #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input logic              clk_xtal,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [8:0]        bus_wdata,
  input logic [8:0]        bus_rdata,
  input logic              cnt_wr_permit,
  input logic              sec_en,
  input logic              tick_pulse,
  input logic              clr_now,
  input logic [14:0]       div_q,
  input logic              tick_ovr,
  input logic [3:0]        tick_code
);
  logic wr_hit, wr_miss;
  assign wr_hit  = bus_we && (bus_addr == CTRL_ADDR);
  assign wr_miss = bus_we && (bus_addr != CTRL_ADDR);

  a_r1_div_held: assert property (@(posedge clk_xtal) !rst_n |=> (div_q == '0) || !rst_n);
  a_r2_permit_follows: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    wr_hit |=> cnt_wr_permit == $past(bus_wdata[0]));
  a_r4_sec_wraps: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    sec_en |=> div_q == '0);
  a_r5_clear_zero: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    clr_now |=> div_q == '0);
  a_r5_bit3_reads_zero: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    !bus_rdata[3]);
  a_r6_ovr_every: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    tick_ovr |-> tick_pulse);
  a_r8_code15_quiet: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (!tick_ovr && tick_code == 4'd15) |-> !tick_pulse);
  a_r9_single_tick: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    (tick_pulse && !tick_ovr && !wr_hit) |=> !tick_pulse);
  a_r10_miss_ignored: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    wr_miss |=> $stable(cnt_wr_permit));
endmodule

bind rtc_tick_ctrl rtc_tick_ctrl_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk_xtal(clk_xtal), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_wr_permit(cnt_wr_permit),
  .sec_en(sec_en), .tick_pulse(tick_pulse), .clr_now(clr_now), .div_q(div_q),
  .tick_ovr(tick_ovr), .tick_code(tick_code)
);

// File: tb/rtc_tick_ctrl_tb.sv
module rtc_tick_ctrl_tb;
  logic       clk_xtal = 1'b0;
  logic       rst_n    = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_we   = 1'b0;
  logic [8:0] bus_wdata = '0;
  logic [8:0] bus_rdata;
  logic       cnt_wr_permit, sec_en, tick_pulse;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  int    exp_q[$];
  int    sec_base = 0;
  bit    mon_on = 1'b0;
  string phase_req = "R7";

  always #2.5 clk_xtal = ~clk_xtal;
  always @(posedge clk_xtal) cyc <= cyc + 1;

  rtc_tick_ctrl u_dut (
    .clk_xtal(clk_xtal), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_wr_permit(cnt_wr_permit),
    .sec_en(sec_en), .tick_pulse(tick_pulse)
  );

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // period in crystal cycles for each rate code (0 = silent)
  function automatic int period_of(bit ovr, int code);
    int tbl[16] = '{2, 4, 8, 16, 256, 32768, 32, 64, 128, 512,
                    1024, 2048, 4096, 8192, 16384, 0};
    return ovr ? 1 : tbl[code];
  endfunction

  task automatic bus_write(logic [3:0] a, logic [8:0] d);
    @(negedge clk_xtal);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk_xtal);
    bus_we = 1'b0; bus_addr = '0;
  endtask

  task automatic bus_read_check(logic [3:0] a, logic [8:0] exp, string req);
    @(negedge clk_xtal);
    bus_addr = a;
    #1 check(req, bus_rdata, exp, "read data");
    bus_addr = '0;
  endtask

  // driver: configure + clear, push expected tick cycles, watch window
  task automatic run_phase(string req, logic [8:0] d, int w);
    int p, seen0;
    mon_on = 1'b0;
    phase_req = req;
    bus_write(4'h0, d | 9'h008);
    p = period_of(d[4], int'(d[8:5]));
    sec_base = cyc;
    if (p > 0)
      for (int t = cyc + p - 1; t < cyc + w; t += p) exp_q.push_back(t);
    seen0 = checks;
    mon_on = 1'b1;
    repeat (w) @(negedge clk_xtal);
    mon_on = 1'b0;
    check(req, exp_q.size(), 0, "missed ticks left in queue");
    exp_q.delete();
  endtask

  // monitor: pop and compare each observed tick, track seconds enable
  always @(negedge clk_xtal) begin : mon
    int t;
    #1;
    if (mon_on) begin
      if (tick_pulse) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL %s unexpected tick: actual cycle %0d expected none", phase_req, cyc);
        end else begin
          t = exp_q.pop_front();
          check(phase_req, cyc, t, "tick cycle");
        end
      end
      if (sec_en || (((cyc - sec_base) % 32768) == 32767))
        check("R4", sec_en, (((cyc - sec_base) % 32768) == 32767), "seconds enable");
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk_xtal);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_xtal);
    check("R1", bus_rdata, 0, "reset read");
    check("R1", cnt_wr_permit, 0, "reset permit");
    check("R1", sec_en | tick_pulse, 0, "reset outputs");
    rst_n = 1'b1;

    bus_write(4'h0, 9'h001);
    #1 check("R2", cnt_wr_permit, 1, "permit after enable");
    bus_write(4'h0, 9'h1E0);
    #1 check("R2", cnt_wr_permit, 0, "permit after disable");
    bus_read_check(4'h0, 9'h1E0, "R2");

    bus_write(4'h0, 9'h006);
    bus_read_check(4'h0, 9'h006, "R3");
    bus_write(4'h0, 9'h00F);
    bus_read_check(4'h0, 9'h007, "R5");

    bus_write(4'h5, 9'h000);
    bus_read_check(4'h0, 9'h007, "R10");
    check("R10", cnt_wr_permit, 1, "permit after miss write");
    bus_read_check(4'h5, 9'h000, "R10");

    for (int c = 0; c < 15; c++) begin
      int p = period_of(1'b0, c);
      int w = (p == 32768) ? 32768 + 4 : 2 * p + 3;
      logic [8:0] d = 9'(c << 5) | 9'h001 | ((c % 2 == 1) ? 9'h006 : 9'h000);
      run_phase((c % 2 == 1) ? "R3" : "R7", d, w);
    end
    run_phase("R8", 9'h1E1, 200);
    run_phase("R6", 9'h0F1, 20);
    run_phase("R6", 9'h1F7, 20);
    run_phase("R9", 9'h001, 10);
    finish_run();
  end
endmodule